// File: doc/BRIEF.md
# Adaptive inter-packet delay controller

This block sets the number of idle clock cycles that a packet transmitter waits between consecutive data packets. The transmitter raises a one-cycle pulse for every packet it sends, and at the same time raises a flag when that send is a retransmission. The block counts both kinds of event over fixed windows of sent packets. When a window closes it compares the retransmissions with the total number of sends and moves the gap.

Retransmissions show that acknowledgements arrive too late or that packets are dropped. When there are too many of them, the gap grows quickly so that the receiver gets time to recover. A window with no retransmission at all lets the gap shrink slowly, and any ratio between these two limits leaves it where it is. The gap always stays between a configured floor and ceiling. The transmitter reads the current value on `gap_o`.

Top module: `pkt_gap_governor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `gap_o` equals GAP_INIT (default 64).
- R2: A window closes on the clock edge that samples the 2^WIN_LOG2-th (default 256th) send pulse counted since reset or since the previous window closed. Any change of `gap_o` is visible on the cycle after that edge. The closing send's retransmission flag counts in that window, and reset discards a partly filled window.
- R3: `pkt_retx_i` is ignored on cycles when `pkt_sent_i` is low.
- R4: If, at a window close, the retransmission count times 2^RATIO_SHIFT (default 16) exceeds the window size, meaning more than 16 of 256, the gap becomes min(2*gap+1, GAP_MAX).
- R5: If a window closes with zero retransmissions, the gap decreases by gap>>DEC_SHIFT (default gap/8, rounded down). When DEC_FLOOR=1 that step is at least 1. The result is never below GAP_MIN.
- R6: If a window closes with 1 to 16 retransmissions (default parameters), the gap is unchanged. Exactly 16 counts as unchanged.
- R7: `gap_o` changes only on the cycle after a window close.
- R8: `gap_o` always lies within [GAP_MIN, GAP_MAX] (defaults 4 and 4000). Repeated increases saturate at GAP_MAX, and repeated decreases settle at GAP_MIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_sent_i | input | 1 | One pulse per packet sent |
| pkt_retx_i | input | 1 | Marks the send on the same cycle as a retransmission |
| gap_o | output | GAP_W | Current idle gap in clock cycles |

## Verification
The assertions check on every cycle that the gap stays inside its limits and holds still between window closes. They also check that a closing window never moves the gap against its verdict, and that the retransmission count never runs ahead of the send count.

Only the bench scenarios can show the following:
- the exact arithmetic of the doubling and eighth-step updates;
- the threshold boundary at exactly 16 retransmissions compared with 17;
- that idle-cycle flags are ignored;
- that a mid-window reset restarts the count.

// File: rtl/gapctl_pkg.sv
package gapctl_pkg;
   typedef enum logic [1:0] {
      VERD_HOLD  = 2'd0,
      VERD_SLOW  = 2'd1,
      VERD_SPEED = 2'd2
   } verdict_t;
endpackage

// File: rtl/gapctl_window.sv
module gapctl_window #(
   parameter int WIN_LOG2 = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sent_i,
   input  logic                retx_i,
   output logic                done_o,
   output logic [WIN_LOG2:0]   retx_tot_o
);
   localparam int CW = WIN_LOG2 + 1;

   logic [WIN_LOG2-1:0] sent_cnt;
   logic [CW-1:0]       retx_cnt;
   logic                retx_hit;

   assign retx_hit   = sent_i & retx_i;
   assign done_o     = sent_i && (sent_cnt == {WIN_LOG2{1'b1}});
   assign retx_tot_o = retx_cnt + CW'(retx_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sent_cnt <= '0;
         retx_cnt <= '0;
      end else if (done_o) begin
         sent_cnt <= '0;
         retx_cnt <= '0;
      end else if (sent_i) begin
         sent_cnt <= sent_cnt + 1'b1;
         retx_cnt <= retx_cnt + CW'(retx_hit);
      end
   end

   // R3
   retx_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retx_cnt <= {1'b0, sent_cnt});

   // R3
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sent_i |=> ($stable(sent_cnt) && $stable(retx_cnt)));
endmodule

// File: rtl/gapctl_judge.sv
module gapctl_judge
   import gapctl_pkg::*;
#(
   parameter int WIN_LOG2    = 8,
   parameter int RATIO_SHIFT = 4
) (
   input  logic [WIN_LOG2:0] retx_tot_i,
   output verdict_t          verd_o
);
   localparam int PW = WIN_LOG2 + 1 + RATIO_SHIFT;
   localparam logic [PW-1:0] WIN_SIZE = PW'(1) << WIN_LOG2;

   logic [PW-1:0] scaled;
   assign scaled = PW'(retx_tot_i) << RATIO_SHIFT;

   always_comb begin
      if (retx_tot_i == '0)
         verd_o = VERD_SPEED;
      else if (scaled > WIN_SIZE)
         verd_o = VERD_SLOW;
      else
         verd_o = VERD_HOLD;
   end
endmodule

// File: rtl/gapctl_stepper.sv
module gapctl_stepper
   import gapctl_pkg::*;
#(
   parameter int GAP_W     = 16,
   parameter int GAP_MIN   = 4,
   parameter int GAP_MAX   = 4000,
   parameter int GAP_INIT  = 64,
   parameter int DEC_SHIFT = 3,
   parameter bit DEC_FLOOR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  verdict_t         verd_i,
   output logic [GAP_W-1:0] gap_o
);
   localparam int WW = GAP_W + 1;
   localparam logic [GAP_W-1:0] MIN_V  = GAP_MIN[GAP_W-1:0];
   localparam logic [GAP_W-1:0] MAX_V  = GAP_MAX[GAP_W-1:0];
   localparam logic [GAP_W-1:0] INIT_V = GAP_INIT[GAP_W-1:0];

   logic [WW-1:0]    grow;
   logic [GAP_W-1:0] up_val;
   logic [GAP_W-1:0] dec_step;
   logic [GAP_W-1:0] down_val;
   logic [GAP_W-1:0] gap_nxt;

   assign grow   = {gap_o, 1'b1};
   assign up_val = (grow > {1'b0, MAX_V}) ? MAX_V : grow[GAP_W-1:0];

   generate
      if (DEC_FLOOR) begin : g_floor
         logic [GAP_W-1:0] raw;
         assign raw      = gap_o >> DEC_SHIFT;
         assign dec_step = (raw == '0) ? GAP_W'(1) : raw;
      end else begin : g_plain
         assign dec_step = gap_o >> DEC_SHIFT;
      end
   endgenerate

   assign down_val = ({1'b0, gap_o} >= ({1'b0, MIN_V} + {1'b0, dec_step}))
                     ? (gap_o - dec_step) : MIN_V;

   always_comb begin
      unique case (verd_i)
         VERD_SLOW:  gap_nxt = up_val;
         VERD_SPEED: gap_nxt = down_val;
         default:    gap_nxt = gap_o;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      gap_o <= INIT_V;
      else if (step_i) gap_o <= gap_nxt;
   end

   // R8
   gap_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_o >= MIN_V) && (gap_o <= MAX_V));

   // R7
   gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(gap_o));

   // R4
   slow_no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && verd_i == VERD_SLOW) |=> (gap_o >= $past(gap_o)));

   // R5
   speed_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && verd_i == VERD_SPEED) |=> (gap_o <= $past(gap_o)));

   // R6
   hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && verd_i == VERD_HOLD) |=> $stable(gap_o));
endmodule

// File: rtl/pkt_gap_governor.sv
module pkt_gap_governor
   import gapctl_pkg::*;
#(
   parameter int GAP_W       = 16,
   parameter int WIN_LOG2    = 8,
   parameter int RATIO_SHIFT = 4,
   parameter int DEC_SHIFT   = 3,
   parameter bit DEC_FLOOR   = 1'b1,
   parameter int GAP_MIN     = 4,
   parameter int GAP_MAX     = 4000,
   parameter int GAP_INIT    = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_sent_i,
   input  logic             pkt_retx_i,
   output logic [GAP_W-1:0] gap_o
);
   generate
      if (WIN_LOG2 < 1 || WIN_LOG2 > 24) begin : g_bad_win
         $error("WIN_LOG2 out of range");
      end
      if (GAP_W < 2 || GAP_W > 31) begin : g_bad_w
         $error("GAP_W out of range");
      end
      if (GAP_MIN < 0 || GAP_MIN > GAP_INIT || GAP_INIT > GAP_MAX) begin : g_bad_ord
         $error("need GAP_MIN <= GAP_INIT <= GAP_MAX");
      end
      if (GAP_MAX >= (1 << GAP_W)) begin : g_bad_max
         $error("GAP_MAX does not fit GAP_W");
      end
      if (DEC_SHIFT < 1 || DEC_SHIFT >= GAP_W) begin : g_bad_dec
         $error("DEC_SHIFT out of range");
      end
   endgenerate

   logic                win_done;
   logic [WIN_LOG2:0]   retx_tot;
   verdict_t            verd;

   gapctl_window #(.WIN_LOG2(WIN_LOG2)) u_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .sent_i     (pkt_sent_i),
      .retx_i     (pkt_retx_i),
      .done_o     (win_done),
      .retx_tot_o (retx_tot)
   );

   gapctl_judge #(.WIN_LOG2(WIN_LOG2), .RATIO_SHIFT(RATIO_SHIFT)) u_judge (
      .retx_tot_i (retx_tot),
      .verd_o     (verd)
   );

   gapctl_stepper #(
      .GAP_W     (GAP_W),
      .GAP_MIN   (GAP_MIN),
      .GAP_MAX   (GAP_MAX),
      .GAP_INIT  (GAP_INIT),
      .DEC_SHIFT (DEC_SHIFT),
      .DEC_FLOOR (DEC_FLOOR)
   ) u_stepper (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (win_done),
      .verd_i (verd),
      .gap_o  (gap_o)
   );
endmodule

// File: tb/pkt_gap_governor_tb.sv
module pkt_gap_governor_tb;
   localparam int GMIN = 4, GMAX = 4000, GINIT = 64, WIN = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sent = 1'b0;
   logic        retx = 1'b0;
   logic [15:0] gap;

   int errors = 0, checks = 0, model = GINIT, cycles = 0;

   always #10 clk = ~clk;

   pkt_gap_governor u_dut (
      .clk(clk), .rst_n(rst_n), .pkt_sent_i(sent), .pkt_retx_i(retx), .gap_o(gap)
   );

   function automatic int exp_inc(int g);
      int v = 2 * g + 1;
      return (v > GMAX) ? GMAX : v;
   endfunction

   function automatic int exp_dec(int g);
      int s = g >> 3;
      if (s == 0) s = 1;
      return (g >= GMIN + s) ? g - s : GMIN;
   endfunction

   function automatic int exp_after(int g, int n);
      if (n == 0) return exp_dec(g);
      if (n * 16 > WIN) return exp_inc(g);
      return g;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s gap actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // sends nsend packets, nretx of them marked; idle cycles carry random retx
   task automatic feed(int nsend, int nretx, bit noisy);
      int off = $urandom % WIN;
      for (int k = 0; k < nsend; k++) begin
         int idle = $urandom % 3;
         for (int i = 0; i < idle; i++) begin
            sent = 1'b0;
            retx = noisy ? 1'b1 : 1'($urandom);
            @(negedge clk);
         end
         sent = 1'b1;
         retx = (((k * 7 + off) % WIN) < nretx);
         @(negedge clk);
         if (k == nsend / 2) check("R7 mid-window", int'(gap), model);
      end
      sent = 1'b0;
      retx = 1'b0;
   endtask

   task automatic window(string req, int nretx, bit noisy);
      feed(WIN, nretx, noisy);
      model = exp_after(model, nretx);
      check(req, int'(gap), model);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         errors++;
         $display("FAIL R2 watchdog actual=timeout expected=done");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd13));
      // R1: value during reset, with activity on the inputs
      repeat (3) begin
         sent = 1'($urandom); retx = 1'($urandom);
         @(negedge clk);
      end
      sent = 1'b0; retx = 1'b0;
      check("R1 in reset", int'(gap), GINIT);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", int'(gap), GINIT);

      // R2: window closes exactly on 256th send
      feed(WIN - 1, 0, 1'b0);
      @(negedge clk);
      check("R2 before close", int'(gap), GINIT);
      sent = 1'b1; retx = 1'b0;
      @(negedge clk);
      sent = 1'b0;
      model = exp_dec(GINIT);
      check("R2 close at 256", int'(gap), model);

      // R6 boundary and R4 boundary; closing send marked
      window("R6 exactly 16", 16, 1'b0);
      window("R6 one retx", 1, 1'b0);
      window("R4 seventeen", 17, 1'b0);
      window("R4 all retx", 256, 1'b0);
      // R3: idle-cycle flags held high must not count
      window("R3 idle retx ignored", 16, 1'b1);
      window("R3 idle retx ignored zero", 0, 1'b1);

      // R2: reset discards a partly filled window
      feed(200, 0, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model = GINIT;
      @(negedge clk);
      check("R1 re-reset", int'(gap), GINIT);
      feed(100, 0, 1'b0);
      @(negedge clk);
      check("R2 partial discarded", int'(gap), GINIT);
      feed(WIN - 100, 0, 1'b0);
      @(negedge clk);
      model = exp_dec(GINIT);
      check("R2 restart count", int'(gap), model);

      // R5/R8: settle at the floor
      for (int w = 0; w < 26; w++) window("R5 decrease", 0, 1'b0);
      check("R8 floor", int'(gap), GMIN);
      window("R8 floor hold", 0, 1'b0);

      // R4/R8: saturate at the ceiling
      for (int w = 0; w < 11; w++) window("R4 increase", 40, 1'b0);
      check("R8 ceiling", int'(gap), GMAX);
      window("R5 from ceiling", 0, 1'b0);

      // random windows
      for (int w = 0; w < 24; w++) begin
         int r = $urandom % 4;
         int n = (r == 0) ? 0 : (r == 1) ? 1 + $urandom % 16 : 17 + $urandom % 60;
         window("R4/R5/R6 random", n, 1'b0);
      end
      finish_run();
   end
endmodule